// File: doc/BRIEF.md
# Bring-up 8-bit Processor Core

This is a multi-cycle 8-bit processor core for early system bring-up. It fetches one byte per machine cycle from a byte-wide memory port and runs a small set of instructions: no-operation, absolute jump, interrupt disable and enable, clearing the accumulator by XOR with itself, 16-bit immediate loads into the stack pointer and HL, and a store of the accumulator into the high I/O page. One clock edge is one machine cycle. The memory port has a combinational read: the byte at `mem_addr` must appear on `mem_rdata` within the same cycle.

When an instruction finishes, the core pulses `instr_done` and reports that instruction's machine-cycle cost on `instr_cycles`. The architectural registers and the interrupt master enable latch are visible as status outputs. Any opcode outside the subset stops the core. It then raises `halt_err`, holds the offending byte on `bad_opcode`, and keeps the program counter pointing at that byte.

Top module: `mini8_core`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, PC is 0x0100, SP is 0xFFFE, HL is 0x0000, A is 0x00, F is 0x00, the interrupt enable latch `ime` is 0 and `halt_err` is 0.
- R2: Opcode 0x00 does nothing else, advances PC by 1 and costs 1 machine cycle.
- R3: Opcode 0xC3 reads two operand bytes, the first being the low half of the target. It loads the target into PC and costs 4 machine cycles.
- R4: Opcode 0xF3 clears `ime`, advances PC by 1 and costs 1 machine cycle. It also cancels an enable that has not yet taken effect.
- R5: Opcode 0xFB costs 1 machine cycle and advances PC by 1. `ime` stays unchanged when 0xFB completes and reads 1 when the next instruction completes.
- R6: Opcode 0xAF leaves A at 0x00 and F at 0x80, advances PC by 1 and costs 1 machine cycle.
- R7: Opcodes 0x31 and 0x21 read two operand bytes, low byte first, and load the 16-bit value into SP (0x31) or HL (0x21). PC advances by 3 and the cost is 3 machine cycles.
- R8: Opcode 0xE0 reads operand n and writes A to address 0xFF00+n, with `mem_wr` high during exactly one cycle. PC advances by 2 and the cost is 3 machine cycles.
- R9: F holds Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Bits 3..0 always read 0.
- R10: On any other opcode the core sets `halt_err`, shows the opcode on `bad_opcode` and leaves PC at the opcode's address. After that, no instruction completes and PC never changes until reset.
- R11: `instr_done` is high for exactly one cycle after each completed instruction, and `instr_cycles` then gives that instruction's cost. The sequence 0x00, 0xC3 0x50 0x01, 0xF3 totals 6 machine cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one edge per machine cycle |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory address for this machine cycle |
| mem_rdata | input | 8 | Byte read at `mem_addr` in the same cycle |
| mem_wr | output | 1 | Write strobe for the high-page store |
| mem_wdata | output | 8 | Data to write (the accumulator) |
| ime | output | 1 | Interrupt master enable latch |
| instr_done | output | 1 | One-cycle pulse after an instruction completes |
| instr_cycles | output | 3 | Machine-cycle cost of the instruction just completed |
| halt_err | output | 1 | Core stopped on an unimplemented opcode |
| bad_opcode | output | 8 | The opcode that stopped the core |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| hl_o | output | 16 | HL register pair |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 8 | Flag register |

## Verification
An instruction completes on the clock edge of its last machine cycle. `instr_done`, `instr_cycles`, PC and the other registers all change on that same edge. The bench therefore samples at each falling edge and, whenever it sees `instr_done`, records the cycle cost, PC and `ime` for that instruction. This is why the delayed enable shows up exactly one completed instruction after 0xFB. The write strobe of the store is combinational during that instruction's third cycle, and the bench captures it at that cycle's falling edge. A stopped core is observed over several cycles to confirm that PC does not move and that no completion pulse appears.

// File: rtl/mini8_pkg.sv
package mini8_pkg;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_OPLO,
    ST_OPHI,
    ST_JUMP,
    ST_IOWR,
    ST_STOP
  } phase_t;

  typedef enum logic [3:0] {
    K_NOP,
    K_JUMP,
    K_IOFF,
    K_ION,
    K_CLRA,
    K_LDSP,
    K_LDHL,
    K_IOST,
    K_BAD
  } kind_t;

  localparam logic [7:0] OPC_NOP  = 8'h00;
  localparam logic [7:0] OPC_JUMP = 8'hC3;
  localparam logic [7:0] OPC_IOFF = 8'hF3;
  localparam logic [7:0] OPC_ION  = 8'hFB;
  localparam logic [7:0] OPC_CLRA = 8'hAF;
  localparam logic [7:0] OPC_LDSP = 8'h31;
  localparam logic [7:0] OPC_LDHL = 8'h21;
  localparam logic [7:0] OPC_IOST = 8'hE0;

endpackage

// File: rtl/mini8_decode.sv
module mini8_decode
  import mini8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opcode,
  output kind_t         kind
);

  always_comb begin
    case (opcode)
      OPC_NOP:  kind = K_NOP;
      OPC_JUMP: kind = K_JUMP;
      OPC_IOFF: kind = K_IOFF;
      OPC_ION:  kind = K_ION;
      OPC_CLRA: kind = K_CLRA;
      OPC_LDSP: kind = K_LDSP;
      OPC_LDHL: kind = K_LDHL;
      OPC_IOST: kind = K_IOST;
      default:  kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/mini8_ime.sv
module mini8_ime (
  input  logic clk,
  input  logic rst,
  input  logic retire,
  input  logic ret_off,
  input  logic ret_on,
  output logic ime
);

  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      ime   <= 1'b0;
      armed <= 1'b0;
    end else if (retire) begin
      if (ret_off) begin
        ime   <= 1'b0;
        armed <= 1'b0;
      end else if (ret_on) begin
        if (armed) ime <= 1'b1;
        armed <= 1'b1;
      end else if (armed) begin
        ime   <= 1'b1;
        armed <= 1'b0;
      end
    end
  end

  // R5: the latch only rises at a completion that follows an armed enable
  a_r5_delayed_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(ime) |-> $past(retire) && $past(armed));

  // R4: a completed disable leaves the latch low
  a_r4_disable_clears: assert property (@(posedge clk) disable iff (rst)
    retire && ret_off |=> !ime);

endmodule

// File: rtl/mini8_cycmeter.sv
module mini8_cycmeter #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          retire,
  output logic          done,
  output logic [CW-1:0] cycles
);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      cycles  <= '0;
      done    <= 1'b0;
    end else begin
      done <= retire;
      if (retire) begin
        cycles  <= run_cnt + CW'(1);
        run_cnt <= '0;
      end else if (step) begin
        run_cnt <= run_cnt + CW'(1);
      end
    end
  end

  // R11: a reported cost is one of the subset's costs
  a_r11_cost_legal: assert property (@(posedge clk) disable iff (rst)
    done |-> (cycles == CW'(1) || cycles == CW'(3) || cycles == CW'(4)));

  // R11: the completion pulse is a single cycle for single-cycle gaps
  a_r11_pulse_after_retire: assert property (@(posedge clk) disable iff (rst)
    retire |=> done);

endmodule

// File: rtl/mini8_core.sv
module mini8_core
  import mini8_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          CW      = 3,
  parameter logic [15:0] RST_PC  = 16'h0100,
  parameter logic [15:0] RST_SP  = 16'hFFFE,
  parameter logic [7:0]  IO_PAGE = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  output logic [15:0]   mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic          ime,
  output logic          instr_done,
  output logic [CW-1:0] instr_cycles,
  output logic          halt_err,
  output logic [DW-1:0] bad_opcode,
  output logic [15:0]   pc_o,
  output logic [15:0]   sp_o,
  output logic [15:0]   hl_o,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] flags_o
);

  localparam int AW = 2 * DW;

  phase_t        phase;
  kind_t         dec_kind;
  kind_t         cur_kind;
  logic [AW-1:0] pc, sp, hl;
  logic [DW-1:0] acc;
  logic [DW-1:0] imm_lo, imm_hi;
  logic          fz, fn, fh, fc;
  logic          retire, step, ret_off, ret_on;

  mini8_decode #(.DW(DW)) u_dec (
    .opcode (mem_rdata),
    .kind   (dec_kind)
  );

  always_comb begin
    retire = 1'b0;
    case (phase)
      ST_FETCH: retire = (dec_kind == K_NOP) || (dec_kind == K_IOFF) ||
                         (dec_kind == K_ION) || (dec_kind == K_CLRA);
      ST_OPHI:  retire = (cur_kind != K_JUMP);
      ST_JUMP:  retire = 1'b1;
      ST_IOWR:  retire = 1'b1;
      default:  retire = 1'b0;
    endcase
  end

  assign step    = (phase != ST_STOP) && !((phase == ST_FETCH) && (dec_kind == K_BAD));
  assign ret_off = (phase == ST_FETCH) && (dec_kind == K_IOFF);
  assign ret_on  = (phase == ST_FETCH) && (dec_kind == K_ION);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= ST_FETCH;
      cur_kind   <= K_NOP;
      pc         <= RST_PC;
      sp         <= RST_SP;
      hl         <= '0;
      acc        <= '0;
      imm_lo     <= '0;
      imm_hi     <= '0;
      {fz, fn, fh, fc} <= 4'b0000;
      halt_err   <= 1'b0;
      bad_opcode <= '0;
    end else begin
      case (phase)
        ST_FETCH: begin
          case (dec_kind)
            K_BAD: begin
              phase      <= ST_STOP;
              halt_err   <= 1'b1;
              bad_opcode <= mem_rdata;
            end
            K_CLRA: begin
              acc <= acc ^ acc;
              fz  <= 1'b1;
              fn  <= 1'b0;
              fh  <= 1'b0;
              fc  <= 1'b0;
              pc  <= pc + AW'(1);
            end
            K_NOP, K_IOFF, K_ION: pc <= pc + AW'(1);
            default: begin
              cur_kind <= dec_kind;
              pc       <= pc + AW'(1);
              phase    <= ST_OPLO;
            end
          endcase
        end
        ST_OPLO: begin
          imm_lo <= mem_rdata;
          pc     <= pc + AW'(1);
          phase  <= (cur_kind == K_IOST) ? ST_IOWR : ST_OPHI;
        end
        ST_OPHI: begin
          pc <= pc + AW'(1);
          case (cur_kind)
            K_JUMP: begin
              imm_hi <= mem_rdata;
              phase  <= ST_JUMP;
            end
            K_LDSP: begin
              sp    <= {mem_rdata, imm_lo};
              phase <= ST_FETCH;
            end
            default: begin
              hl    <= {mem_rdata, imm_lo};
              phase <= ST_FETCH;
            end
          endcase
        end
        ST_JUMP: begin
          pc    <= {imm_hi, imm_lo};
          phase <= ST_FETCH;
        end
        ST_IOWR: phase <= ST_FETCH;
        default: phase <= ST_STOP;
      endcase
    end
  end

  assign mem_addr  = (phase == ST_IOWR) ? {IO_PAGE, imm_lo} : pc;
  assign mem_wr    = (phase == ST_IOWR);
  assign mem_wdata = acc;

  mini8_ime u_ime (
    .clk     (clk),
    .rst     (rst),
    .retire  (retire),
    .ret_off (ret_off),
    .ret_on  (ret_on),
    .ime     (ime)
  );

  mini8_cycmeter #(.CW(CW)) u_meter (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .retire (retire),
    .done   (instr_done),
    .cycles (instr_cycles)
  );

  assign pc_o    = pc;
  assign sp_o    = sp;
  assign hl_o    = hl;
  assign acc_o   = acc;
  assign flags_o = {fz, fn, fh, fc, 4'b0000};

  // R1: first cycle after reset shows the reset vector and stack top
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc_o == RST_PC) && (sp_o == RST_SP) && !ime && !halt_err);

  // R9: low nibble of the flag register never holds a one
  a_r9_flag_low_zero: assert property (@(posedge clk) disable iff (rst)
    flags_o[3:0] == 4'b0000);

  // R10: a stopped core keeps its PC and never completes again
  a_r10_stop_holds: assert property (@(posedge clk) disable iff (rst)
    halt_err |=> halt_err && $stable(pc_o) && !instr_done);

  // R8: writes only reach the high I/O page
  a_r8_write_page: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> mem_addr[15:8] == IO_PAGE);

  // R6: clearing the accumulator yields only the zero flag
  a_r6_clear_flags: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_FETCH) && (mem_rdata == OPC_CLRA) |=> (acc_o == '0) && (flags_o == 8'h80));

endmodule

// File: tb/mini8_core_bench.sv
module mini8_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        mem_wr;
  logic [7:0]  mem_wdata;
  logic        ime, instr_done, halt_err;
  logic [2:0]  instr_cycles;
  logic [7:0]  bad_opcode, acc_o, flags_o;
  logic [15:0] pc_o, sp_o, hl_o;

  logic [7:0] mem [0:1023];

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  int          rec_cyc [0:7];
  logic [15:0] rec_pc  [0:7];
  logic        rec_ime [0:7];
  int          wr_count;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;

  always #4 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:0]];

  mini8_core u_mini8_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .ime(ime),
    .instr_done(instr_done), .instr_cycles(instr_cycles),
    .halt_err(halt_err), .bad_opcode(bad_opcode), .pc_o(pc_o),
    .sp_o(sp_o), .hl_o(hl_o), .acc_o(acc_o), .flags_o(flags_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // run until n instructions complete; record per-instruction cost, PC, ime
  task automatic run(input int n);
    int got = 0;
    int waited = 0;
    wr_count = 0;
    while (got < n && waited < 100) begin
      @(negedge clk);
      waited++;
      if (mem_wr) begin
        wr_count++;
        wr_addr = mem_addr;
        wr_data = mem_wdata;
      end
      if (instr_done) begin
        rec_cyc[got] = int'(instr_cycles);
        rec_pc[got]  = pc_o;
        rec_ime[got] = ime;
        got++;
      end
    end
    if (got < n) check("R11", "instructions completed", got, n);
  endtask

  task automatic t_reset();
    clear_mem();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "pc in reset", pc_o, 16'h0100);
    check("R1", "sp in reset", sp_o, 16'hFFFE);
    do_reset();
    check("R1", "pc after reset", pc_o, 16'h0100);
    check("R1", "sp after reset", sp_o, 16'hFFFE);
    check("R1", "hl after reset", hl_o, 16'h0000);
    check("R1", "acc after reset", acc_o, 8'h00);
    check("R1", "flags after reset", flags_o, 8'h00);
    check("R1", "ime after reset", ime, 1'b0);
    check("R1", "halt after reset", halt_err, 1'b0);
  endtask

  task automatic t_boot();
    int sum;
    clear_mem();
    mem[10'h100] = 8'h00;
    mem[10'h101] = 8'hC3; mem[10'h102] = 8'h50; mem[10'h103] = 8'h01;
    mem[10'h150] = 8'hF3;
    mem[10'h151] = 8'hD3;
    do_reset();
    run(3);
    check("R2", "nop cost", rec_cyc[0], 1);
    check("R2", "nop pc", rec_pc[0], 16'h0101);
    check("R3", "jump cost", rec_cyc[1], 4);
    check("R3", "jump target", rec_pc[1], 16'h0150);
    check("R4", "disable cost", rec_cyc[2], 1);
    check("R4", "disable pc", rec_pc[2], 16'h0151);
    check("R4", "ime after disable", rec_ime[2], 1'b0);
    sum = rec_cyc[0] + rec_cyc[1] + rec_cyc[2];
    check("R11", "boot total cycles", sum, 6);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R10", "no completion when stopped", instr_done, 1'b0);
    end
    check("R10", "halt flag", halt_err, 1'b1);
    check("R10", "offending opcode", bad_opcode, 8'hD3);
    check("R10", "pc at opcode", pc_o, 16'h0151);
  endtask

  task automatic t_enable_delay();
    clear_mem();
    mem[10'h100] = 8'hFB;
    mem[10'h101] = 8'h00;
    mem[10'h102] = 8'h00;
    do_reset();
    run(2);
    check("R5", "enable cost", rec_cyc[0], 1);
    check("R5", "enable pc", rec_pc[0], 16'h0101);
    check("R5", "ime right after enable", rec_ime[0], 1'b0);
    check("R5", "ime after next instruction", rec_ime[1], 1'b1);
  endtask

  task automatic t_enable_cancel();
    clear_mem();
    mem[10'h100] = 8'hFB;
    mem[10'h101] = 8'hF3;
    mem[10'h102] = 8'h00;
    do_reset();
    run(3);
    check("R4", "ime after enable", rec_ime[0], 1'b0);
    check("R4", "ime after cancelling disable", rec_ime[1], 1'b0);
    check("R4", "ime stays off", rec_ime[2], 1'b0);
  endtask

  task automatic t_clear_acc();
    clear_mem();
    mem[10'h100] = 8'hAF;
    do_reset();
    run(1);
    check("R6", "clear cost", rec_cyc[0], 1);
    check("R6", "clear pc", rec_pc[0], 16'h0101);
    check("R6", "acc zero", acc_o, 8'h00);
    check("R6", "flags Z only", flags_o, 8'h80);
    check("R9", "flag low nibble", flags_o[3:0], 4'h0);
  endtask

  task automatic t_load16();
    clear_mem();
    mem[10'h100] = 8'h31; mem[10'h101] = 8'h34; mem[10'h102] = 8'h12;
    mem[10'h103] = 8'h21; mem[10'h104] = 8'hCD; mem[10'h105] = 8'hAB;
    do_reset();
    run(1);
    check("R7", "sp load cost", rec_cyc[0], 3);
    check("R7", "sp load pc", rec_pc[0], 16'h0103);
    check("R7", "sp value", sp_o, 16'h1234);
    run(1);
    check("R7", "hl load cost", rec_cyc[0], 3);
    check("R7", "hl load pc", rec_pc[0], 16'h0106);
    check("R7", "hl value", hl_o, 16'hABCD);
    check("R7", "sp unchanged", sp_o, 16'h1234);
  endtask

  task automatic t_io_store();
    clear_mem();
    mem[10'h100] = 8'hE0; mem[10'h101] = 8'h42;
    do_reset();
    run(1);
    check("R8", "store cost", rec_cyc[0], 3);
    check("R8", "store pc", rec_pc[0], 16'h0102);
    check("R8", "write strobes", wr_count, 1);
    check("R8", "write address", wr_addr, 16'hFF42);
    check("R8", "write data", wr_data, 8'h00);
  endtask

  initial begin
    t_reset();
    t_boot();
    t_enable_delay();
    t_enable_cancel();
    t_clear_acc();
    t_load16();
    t_io_store();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule